// File: doc/BRIEF.md
# GPIO Interrupt Trigger Controller

This block watches a bank of general-purpose input lines, grouped into ports of equal width. The default bank is two ports of 16 pins, 32 lines in all. Each line first passes through a synchroniser. Its trigger condition is then tested every clock, and a hit sets a sticky per-line event flag. Software clears a flag by writing a one to its bit.

A per-line enable mask decides which flags reach the interrupt outputs. There is one interrupt output per port, and it is the OR of that port's enabled flags. There is no setting that turns detection off. A flag therefore latches even while its line is masked, and only the interrupt is gated.

Configuration and flags sit behind a small register port with a write strobe and a read strobe. The port is always ready, so it has no back-pressure and no valid/ready pair. Every pin, register bit and flag of line `L` uses bit `L`.

Top module: `gpio_trig_ctrl`

## Requirements
- R1: Line `L` is pin `L mod 16` of port `L / 16`. Its pin input, enable, mode, both-edge, polarity and flag bits are all bit `L`. Port 0 owns bits 0–15 and drives `irq[0]`; port 1 owns bits 16–31 and drives `irq[1]`.
- R2: While `rst_n` is low, all registers, flags, `bus_rdata` and `irq` are zero.
- R3: A line with its mode bit at 1 (edge), both-edge bit 0 and polarity 1 sets its flag on a rising pin transition only.
- R4: A line with mode 1, both-edge 0 and polarity 0 sets its flag on a falling pin transition only.
- R5: A line with mode 1 and both-edge 1 sets its flag on any pin transition.
- R6: A line with mode 0 (level) sets its flag on every cycle that the synchronised pin equals its polarity bit. Clearing the flag while that level persists leaves it set.
- R7: A write to the flag register clears exactly the flags whose data bit is 1. Zero bits have no effect. A detection in the same cycle as the clear wins.
- R8: Flags latch whatever the enable. `irq[p]` is high exactly while some line of port `p` has both its flag and its enable bit set.
- R9: A pin transition applied between clock edges k-1 and k sets the flag, and any affected `irq`, after edge k+2: two synchroniser edges and one detection edge.
- R10: Register byte offsets are 0x00 enable, 0x04 mode, 0x08 both-edge, 0x0C polarity and 0x10 flag. A write takes effect at the next edge. A read returns the value held before that edge, on `bus_rdata` after the edge. Unmapped offsets read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | 32 | Asynchronous GPIO levels, bit = line index |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the edge after `bus_rd` |
| irq | output | 2 | Per-port interrupt |

## Verification
A pin transition reaches the flag, and through the combinational OR the port interrupt, three clock edges after it is driven. A register write acts at the next edge, and read data appears one edge after the strobe. The bench drives inputs on falling edges and samples on falling edges only. Its directed checks look at the interrupt one, two and three edges after a pin change, and read flags only after at least four edges. A behavioural model steps once per rising edge and is compared with `irq` and `bus_rdata` on every falling edge.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

  localparam int ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFF_ENABLE = 5'h00,
    OFF_MODE   = 5'h04,
    OFF_BOTH   = 5'h08,
    OFF_POL    = 5'h0C,
    OFF_FLAG   = 5'h10
  } reg_off_e;

  typedef enum logic [2:0] {
    TRG_LVL_LO,
    TRG_LVL_HI,
    TRG_FALL,
    TRG_RISE,
    TRG_ANY
  } trig_e;

  function automatic trig_e decode_trig(input logic edge_mode, input logic both,
                                        input logic pol);
    if (!edge_mode) return pol ? TRG_LVL_HI : TRG_LVL_LO;
    if (both) return TRG_ANY;
    return pol ? TRG_RISE : TRG_FALL;
  endfunction

endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= '0;
      else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 2'd2) age <= age + 2'd1;
    end
    // R9: output lags the pin by exactly two edges
    a_r9_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (q == $past(d, 2)));
  end

endmodule

// File: rtl/gtc_detect.sv
module gtc_detect
  import gtc_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl,
  input  logic [LINES-1:0] edge_mode,
  input  logic [LINES-1:0] both,
  input  logic [LINES-1:0] pol,
  output logic [LINES-1:0] hit
);
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    trig_e mode;
    logic  rise, fall;
    assign mode = decode_trig(edge_mode[i], both[i], pol[i]);
    assign rise = lvl[i] & ~prev_q[i];
    assign fall = ~lvl[i] & prev_q[i];
    always_comb begin
      unique case (mode)
        TRG_LVL_LO: hit[i] = ~lvl[i];
        TRG_LVL_HI: hit[i] = lvl[i];
        TRG_FALL:   hit[i] = fall;
        TRG_RISE:   hit[i] = rise;
        TRG_ANY:    hit[i] = rise | fall;
        default:    hit[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gtc_regs.sv
module gtc_regs
  import gtc_pkg::*;
#(
  parameter int LINES = 32,
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [LINES-1:0]  hit,
  output logic [LINES-1:0]  enable_q,
  output logic [LINES-1:0]  mode_q,
  output logic [LINES-1:0]  both_q,
  output logic [LINES-1:0]  pol_q,
  output logic [LINES-1:0]  flag_q,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic [LINES-1:0] wdat;
  logic [LINES-1:0] clr;
  logic             flag_wr;
  logic [BUS_W-1:0] rd_mux;

  assign wdat    = bus_wdata[LINES-1:0];
  assign flag_wr = bus_wr && (bus_addr == OFF_FLAG);
  assign clr     = flag_wr ? wdat : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      mode_q   <= '0;
      both_q   <= '0;
      pol_q    <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFF_ENABLE: enable_q <= wdat;
        OFF_MODE:   mode_q   <= wdat;
        OFF_BOTH:   both_q   <= wdat;
        OFF_POL:    pol_q    <= wdat;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | hit;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFF_ENABLE: rd_mux[LINES-1:0] = enable_q;
      OFF_MODE:   rd_mux[LINES-1:0] = mode_q;
      OFF_BOTH:   rd_mux[LINES-1:0] = both_q;
      OFF_POL:    rd_mux[LINES-1:0] = pol_q;
      OFF_FLAG:   rd_mux[LINES-1:0] = flag_q;
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R7: ones clear their flag unless a detection arrives in the same cycle
  a_r7_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> ((flag_q & $past(wdat) & ~$past(hit)) == '0));
  // R7: a detection always leaves its flag set
  a_r7_detect_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((flag_q & $past(hit)) == $past(hit)));
  // R8: flags are sticky without a clearing write
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R10: enable readback after one edge
  a_r10_read_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFF_ENABLE) |=> (bus_rdata[LINES-1:0] == $past(enable_q)));

endmodule

// File: rtl/gtc_irq_agg.sv
module gtc_irq_agg #(
  parameter int PORTS = 2,
  parameter int PINS  = 16,
  localparam int LINES = PORTS * PINS
) (
  input  logic [LINES-1:0] flag,
  input  logic [LINES-1:0] enable,
  output logic [PORTS-1:0] irq
);
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign irq[p] = |(flag[p*PINS +: PINS] & enable[p*PINS +: PINS]);
  end
endmodule

// File: rtl/gpio_trig_ctrl.sv
module gpio_trig_ctrl
  import gtc_pkg::*;
#(
  parameter int NUM_PORTS     = 2,
  parameter int PINS_PER_PORT = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int BUS_W         = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pins_in,
  input  logic                               bus_wr,
  input  logic                               bus_rd,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [BUS_W-1:0]                   bus_wdata,
  output logic [BUS_W-1:0]                   bus_rdata,
  output logic [NUM_PORTS-1:0]               irq
);
  localparam int LINES = NUM_PORTS * PINS_PER_PORT;

  logic [LINES-1:0] lvl, hit;
  logic [LINES-1:0] enable_q, mode_q, both_q, pol_q, flag_q;

  gtc_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_in), .q(lvl));

  gtc_detect #(.LINES(LINES)) i_detect (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .edge_mode(mode_q),
    .both(both_q), .pol(pol_q), .hit(hit));

  gtc_regs #(.LINES(LINES), .BUS_W(BUS_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .hit(hit),
    .enable_q(enable_q), .mode_q(mode_q), .both_q(both_q), .pol_q(pol_q),
    .flag_q(flag_q), .bus_rdata(bus_rdata));

  gtc_irq_agg #(.PORTS(NUM_PORTS), .PINS(PINS_PER_PORT)) i_agg (
    .flag(flag_q), .enable(enable_q), .irq(irq));

endmodule

// File: tb/test_gpio_trig_ctrl.sv
`timescale 1ns/1ps
module test_gpio_trig_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_trig_ctrl i_gpio_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .pins_in(pins), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  // behavioural reference
  bit [31:0] m_s1, m_s2, m_prev, m_en, m_mode, m_both, m_pol, m_flag, m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_en = 0; m_mode = 0;
      m_both = 0; m_pol = 0; m_flag = 0; m_rdata = 0;
    end else begin
      bit [31:0] hitv, clrv, rv;
      hitv = 0;
      for (int i = 0; i < 32; i++) begin
        bit now, was;
        now = m_s2[i]; was = m_prev[i];
        if (m_mode[i] == 0)      hitv[i] = (now == m_pol[i]);
        else if (m_both[i])      hitv[i] = (now != was);
        else if (m_pol[i])       hitv[i] = now && !was;
        else                     hitv[i] = !now && was;
      end
      clrv = (wr && addr == 5'h10) ? wdata : 0;
      case (addr)
        5'h00: rv = m_en;
        5'h04: rv = m_mode;
        5'h08: rv = m_both;
        5'h0C: rv = m_pol;
        5'h10: rv = m_flag;
        default: rv = 0;
      endcase
      if (rd) m_rdata = rv;
      m_flag = (m_flag & ~clrv) | hitv;
      if (wr) case (addr)
        5'h00: m_en = wdata;
        5'h04: m_mode = wdata;
        5'h08: m_both = wdata;
        5'h0C: m_pol = wdata;
        default: ;
      endcase
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    end
  end

  function automatic bit [1:0] m_irq();
    bit [31:0] a;
    a = m_flag & m_en;
    return {|a[31:16], |a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R8 irq, R10 readback)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq === m_irq(), "R8 irq vs model", {30'd0, irq}, {30'd0, m_irq()});
      chk(rdata === m_rdata, "R10 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    rd = 1; addr = a;
    @(negedge clk);
    rd = 0;
    d = rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    tick(3);
    chk(rdata === 32'h0, "R2 rdata in reset", rdata, 0);
    chk(irq === 2'b00, "R2 irq in reset", {30'd0, irq}, 0);
    rst_n = 1;
    tick(2);
    rreg(5'h10, v);
    chk(v === 32'hFFFF_FFFF, "R8 level-low default latches while masked", v, 32'hFFFF_FFFF);
    chk(irq === 2'b00, "R8 masked flags give no irq", {30'd0, irq}, 0);

    wreg(5'h04, 32'hFFFF_FFFF);
    wreg(5'h0C, 32'h0000_0208);
    wreg(5'h10, 32'hFFFF_FFFF);
    rreg(5'h10, v);
    chk(v === 32'h0, "R7 all flags cleared", v, 0);
    wreg(5'h00, 32'h0010_0008);

    // R9 timing, R3 rising, R1 port A
    pins[3] = 1;
    tick(1);
    chk(irq === 2'b00, "R9 not set after 1 edge", {30'd0, irq}, 0);
    tick(1);
    chk(irq === 2'b00, "R9 not set after 2 edges", {30'd0, irq}, 0);
    tick(1);
    chk(irq === 2'b01, "R9 R3 R1 set after 3 edges on port 0", {30'd0, irq}, 1);

    wreg(5'h10, 32'h8);
    pins[3] = 0;
    tick(4);
    rreg(5'h10, v);
    chk(v[3] === 1'b0, "R3 falling ignored in rising mode", v, 0);

    // R4 falling on line 20, R1 port B
    pins[20] = 1;
    tick(4);
    rreg(5'h10, v);
    chk(v[20] === 1'b0, "R4 rising ignored in falling mode", v, 0);
    pins[20] = 0;
    tick(4);
    chk(irq === 2'b10, "R4 R1 falling raises port 1", {30'd0, irq}, 2);
    rreg(5'h10, v);
    chk(v === 32'h0010_0000, "R1 flag bit position 20", v, 32'h0010_0000);
    wreg(5'h10, 32'h0010_0000);
    chk(irq === 2'b00, "R7 clear drops irq", {30'd0, irq}, 0);

    // R5 both edges on line 7
    wreg(5'h08, 32'h80);
    pins[7] = 1;
    tick(4);
    rreg(5'h10, v);
    chk(v === 32'h80, "R5 rising with both-edge", v, 32'h80);
    wreg(5'h10, 32'h80);
    pins[7] = 0;
    tick(4);
    rreg(5'h10, v);
    chk(v === 32'h80, "R5 falling with both-edge", v, 32'h80);
    wreg(5'h10, 32'h80);

    // R8 latch while masked, enable gates irq
    pins[9] = 1;
    tick(4);
    chk(irq === 2'b00, "R8 masked line no irq", {30'd0, irq}, 0);
    rreg(5'h10, v);
    chk(v === 32'h200, "R8 masked line flag set", v, 32'h200);
    wreg(5'h00, 32'h0010_0208);
    chk(irq === 2'b01, "R8 enabling raises irq", {30'd0, irq}, 1);
    wreg(5'h00, 32'h0010_0008);
    chk(irq === 2'b00, "R8 masking drops irq", {30'd0, irq}, 0);
    wreg(5'h10, 32'h200);

    // R7 zero bits ignored, only ones clear
    pins[3] = 1; pins[7] = 1;
    tick(4);
    wreg(5'h10, 32'h0);
    rreg(5'h10, v);
    chk(v === 32'h88, "R7 zero write no effect", v, 32'h88);
    wreg(5'h10, 32'h8);
    rreg(5'h10, v);
    chk(v === 32'h80, "R7 only ones clear", v, 32'h80);
    wreg(5'h10, 32'h80);

    // R6 level-high on line 12
    wreg(5'h0C, 32'h0000_1208);
    wreg(5'h04, 32'hFFFF_EFFF);
    pins[12] = 1;
    tick(4);
    rreg(5'h10, v);
    chk(v[12] === 1'b1, "R6 level-high sets flag", v, 32'h1000);
    wreg(5'h10, 32'h1000);
    rreg(5'h10, v);
    chk(v[12] === 1'b1, "R6 R7 clear during active level keeps flag", v, 32'h1000);
    pins[12] = 0;
    tick(4);
    wreg(5'h10, 32'h1000);
    rreg(5'h10, v);
    chk(v[12] === 1'b0, "R6 clear after level gone", v, 0);

    // R10 register access
    wreg(5'h00, 32'hA5A5_5A5A);
    rreg(5'h00, v);
    chk(v === 32'hA5A5_5A5A, "R10 enable readback", v, 32'hA5A5_5A5A);
    wr = 1; rd = 1; addr = 5'h00; wdata = 32'h1234_5678;
    @(negedge clk);
    wr = 0; rd = 0;
    chk(rdata === 32'hA5A5_5A5A, "R10 same-cycle read returns old", rdata, 32'hA5A5_5A5A);
    rreg(5'h00, v);
    chk(v === 32'h1234_5678, "R10 write landed", v, 32'h1234_5678);
    wreg(5'h14, 32'hFFFF_FFFF);
    rreg(5'h14, v);
    chk(v === 32'h0, "R10 unmapped reads zero", v, 0);
    rreg(5'h04, v);
    chk(v === 32'hFFFF_EFFF, "R10 mode readback", v, 32'hFFFF_EFFF);
    rreg(5'h08, v);
    chk(v === 32'h80, "R10 both-edge readback", v, 32'h80);
    rreg(5'h0C, v);
    chk(v === 32'h1208, "R10 polarity readback", v, 32'h1208);
    tick(2);
    finish_run();
  end
endmodule